// File: doc/BRIEF.md
# Microcode Execution Trace Controller

This block sits next to a group of small sequencer cores and sends the execution path of one selected core off chip through a single debug pin. Software programs a start address, a stop address, a core-select field, a post-trigger length and an enable bit through a narrow write port. When the enable bit is set, the pin first emits a calibration preamble so that an external receiver can measure the bit rate. The unit then waits for the selected core's program counter to reach the start address. It then streams one 4-bit path code per core step until the stop address is seen and a post-trigger window has elapsed.

The path code comes from the core. It describes how the program counter moved, not where it went. Code 0 is sequential, 1 is a taken jump, 2 is a wait-table branch, 3 is a subroutine return and 15 is a stall. The other values are reserved. The controller forwards these codes unchanged. The selected core is expected to advance once per code frame, which is 2*CODE_W system clocks.

Top module: `trc_trace_ctl`

## Requirements
- R1: After reset, status_o is 0 and dbg_o is low. The status encoding is 0 idle, 1 calibrating, 2 armed, 3 tracing, 4 post-trigger.
- R2: A write to the configuration register (REG_BASE+2) that sets the enable bit (bit POST_W+SEL_W, bit 6 by default) while enable is clear moves status to calibrating on the following cycle. dbg_o is then high on even calibration cycles and low on odd ones, for 2*CAL_PULSES cycles (8 pulses at half clock rate). It is then low for CAL_GAP cycles, after which status becomes armed.
- R3: While armed, tracing starts at the first clock edge at which the selected core's program counter equals the start register (REG_BASE+0). Status then reads 3.
- R4: While tracing or in post-trigger, dbg_o carries the codes back to back with no gaps. Each code is sent MSB first and each bit lasts two cycles. Each code is sampled from the selected lane at the clock edge that starts its frame, and the code values pass unchanged.
- R5: The configuration field at bits [POST_W+SEL_W-1:POST_W] selects lane k. Lane k's program counter is core_pc[k*PC_W +: PC_W] and its code is core_code[k*CODE_W +: CODE_W]. Other lanes have no effect.
- R6: At the edge that closes a tracing frame, if the selected program counter equals the stop register (REG_BASE+1), the unit behaves as follows. With a post-trigger length of 0 (configuration bits [POST_W-1:0]) it goes idle. Otherwise it enters post-trigger, sends that many further frames and then goes idle.
- R7: A post-trigger length of all ones (15 by default) never ends post-trigger on its own.
- R8: A configuration write with the enable bit clear returns the unit to idle on the next cycle from any state, and dbg_o goes low.
- R9: A configuration write with enable set while enable is already set does not restart calibration in any state. After a finished trace, a new trace needs a clear followed by a set.
- R10: Writes to addresses other than the three registers change no state. In idle, dbg_o stays low and status stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| core_pc | input | NUM_CORES*PC_W | Program counters of all lanes, packed |
| core_code | input | NUM_CORES*CODE_W | Path codes of all lanes, packed |
| dbg_o | output | 1 | Serial debug pin |
| status_o | output | 3 | Phase of the trace unit |

## Verification
Every result is due one clock edge after the stimulus that causes it. A register write takes effect at the edge that samples it, and the new status is visible in the cycle after that edge. A start match switches to tracing at the same edge, and the first code bit appears in the next cycle. A stop match acts at the edge that closes the current 8-cycle frame. The bench drives inputs on falling edges and updates its behavioural model on rising edges. It compares status_o and dbg_o a quarter period after every rising edge, so every comparison lands in the cycle where the new value is due. Directed checks at the end of each scenario sample at the same point.

// File: rtl/trc_pkg.sv
package trc_pkg;
   typedef enum logic [2:0] {
      TS_IDLE  = 3'd0,
      TS_CAL   = 3'd1,
      TS_ARMED = 3'd2,
      TS_TRACE = 3'd3,
      TS_POST  = 3'd4
   } trc_state_e;
endpackage

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs #(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 16,
   parameter int PC_W     = 10,
   parameter int SEL_W    = 2,
   parameter int POST_W   = 4,
   parameter int REG_BASE = 'h0C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [PC_W-1:0]   start_pc_o,
   output logic [PC_W-1:0]   stop_pc_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [POST_W-1:0] post_len_o,
   output logic              arm_req_o,
   output logic              kill_o
);
   localparam int EN_BIT = POST_W + SEL_W;
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(REG_BASE);
   localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(REG_BASE + 1);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_BASE + 2);

   logic en_q;
   logic cfg_hit;

   assign cfg_hit   = reg_we && (reg_addr == A_CFG);
   assign arm_req_o = cfg_hit && reg_wdata[EN_BIT] && !en_q;
   assign kill_o    = cfg_hit && !reg_wdata[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pc_o <= '0;
         stop_pc_o  <= '0;
         sel_o      <= '0;
         post_len_o <= '0;
         en_q       <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == A_START) start_pc_o <= reg_wdata[PC_W-1:0];
         if (reg_addr == A_STOP)  stop_pc_o  <= reg_wdata[PC_W-1:0];
         if (cfg_hit) begin
            post_len_o <= reg_wdata[POST_W-1:0];
            sel_o      <= reg_wdata[POST_W +: SEL_W];
            en_q       <= reg_wdata[EN_BIT];
         end
      end
   end
endmodule

// File: rtl/trc_lane_mux.sv
module trc_lane_mux #(
   parameter int NUM_CORES = 4,
   parameter int PC_W      = 10,
   parameter int CODE_W    = 4,
   parameter int SEL_W     = 2
) (
   input  logic [NUM_CORES*PC_W-1:0]   core_pc,
   input  logic [NUM_CORES*CODE_W-1:0] core_code,
   input  logic [SEL_W-1:0]            sel_i,
   output logic [PC_W-1:0]             pc_o,
   output logic [CODE_W-1:0]           code_o
);
   logic [PC_W-1:0]   pc_arr   [NUM_CORES];
   logic [CODE_W-1:0] code_arr [NUM_CORES];

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
      assign pc_arr[g]   = core_pc[g*PC_W +: PC_W];
      assign code_arr[g] = core_code[g*CODE_W +: CODE_W];
   end

   if ((NUM_CORES & (NUM_CORES - 1)) == 0) begin : g_full
      assign pc_o   = pc_arr[sel_i];
      assign code_o = code_arr[sel_i];
   end else begin : g_guard
      logic in_range;
      assign in_range = int'(sel_i) < NUM_CORES;
      assign pc_o     = in_range ? pc_arr[sel_i]   : '0;
      assign code_o   = in_range ? code_arr[sel_i] : '0;
   end
endmodule

// File: rtl/trc_framer.sv
module trc_framer #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              run_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              bit_o,
   output logic              frame_end_o
);
   localparam int SLOT_W = (CODE_W > 1) ? $clog2(2 * CODE_W) : 1;
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(2 * CODE_W - 1);

   logic [CODE_W-1:0] sh_q;
   logic [SLOT_W-1:0] slot_q;

   assign bit_o       = sh_q[CODE_W-1];
   assign frame_end_o = run_i && (slot_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         slot_q <= '0;
      end else if (load_i) begin
         sh_q   <= code_i;
         slot_q <= '0;
      end else if (run_i) begin
         if (slot_q == LAST) begin
            sh_q   <= code_i;
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
            if (slot_q[0]) sh_q <= sh_q << 1;
         end
      end else begin
         slot_q <= '0;
      end
   end
endmodule

// File: rtl/trc_trace_ctl.sv
module trc_trace_ctl
   import trc_pkg::*;
#(
   parameter int NUM_CORES  = 4,
   parameter int PC_W       = 10,
   parameter int CODE_W     = 4,
   parameter int POST_W     = 4,
   parameter int ADDR_W     = 9,
   parameter int DATA_W     = 16,
   parameter int REG_BASE   = 'h0C0,
   parameter int CAL_PULSES = 8,
   parameter int CAL_GAP    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   input  logic [NUM_CORES*PC_W-1:0]   core_pc,
   input  logic [NUM_CORES*CODE_W-1:0] core_code,
   output logic                        dbg_o,
   output logic [2:0]                  status_o
);
   localparam int SEL_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int CAL_LEN = 2 * CAL_PULSES + CAL_GAP;
   localparam int CAL_W   = $clog2(CAL_LEN + 1);
   localparam logic [CAL_W-1:0]  CAL_LAST  = CAL_W'(CAL_LEN - 1);
   localparam logic [CAL_W-1:0]  CAL_BURST = CAL_W'(2 * CAL_PULSES);
   localparam logic [POST_W-1:0] POST_ALL1 = '1;

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("trc_trace_ctl: NUM_CORES must be at least 2");
   end
   if ((CODE_W & (CODE_W - 1)) != 0) begin : g_bad_code
      $error("trc_trace_ctl: CODE_W must be a power of two");
   end
   if (DATA_W < PC_W || DATA_W < POST_W + SEL_W + 1) begin : g_bad_data
      $error("trc_trace_ctl: DATA_W too narrow for the register fields");
   end
   if (CAL_PULSES < 1 || CAL_GAP < 1) begin : g_bad_cal
      $error("trc_trace_ctl: calibration needs at least one pulse and one gap cycle");
   end

   logic [PC_W-1:0]   start_pc, stop_pc, sel_pc;
   logic [SEL_W-1:0]  sel;
   logic [POST_W-1:0] post_len, post_rem_q;
   logic [CODE_W-1:0] sel_code;
   logic              arm_req, kill;
   logic              frame_bit, frame_end, load, run;
   logic [CAL_W-1:0]  cal_q;
   trc_state_e        state_q;

   trc_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W),
      .SEL_W(SEL_W), .POST_W(POST_W), .REG_BASE(REG_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .start_pc_o(start_pc), .stop_pc_o(stop_pc),
      .sel_o(sel), .post_len_o(post_len), .arm_req_o(arm_req), .kill_o(kill)
   );

   trc_lane_mux #(
      .NUM_CORES(NUM_CORES), .PC_W(PC_W), .CODE_W(CODE_W), .SEL_W(SEL_W)
   ) u_mux (
      .core_pc(core_pc), .core_code(core_code), .sel_i(sel),
      .pc_o(sel_pc), .code_o(sel_code)
   );

   assign load = (state_q == TS_ARMED) && (sel_pc == start_pc);
   assign run  = (state_q == TS_TRACE) || (state_q == TS_POST);

   trc_framer #(.CODE_W(CODE_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(run),
      .code_i(sel_code), .bit_o(frame_bit), .frame_end_o(frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TS_IDLE;
         cal_q      <= '0;
         post_rem_q <= '0;
      end else if (kill) begin
         state_q <= TS_IDLE;
      end else if (arm_req) begin
         state_q <= TS_CAL;
         cal_q   <= '0;
      end else begin
         unique case (state_q)
            TS_CAL: begin
               if (cal_q == CAL_LAST) state_q <= TS_ARMED;
               else                   cal_q   <= cal_q + 1'b1;
            end
            TS_ARMED: begin
               if (load) state_q <= TS_TRACE;
            end
            TS_TRACE: begin
               if (frame_end && (sel_pc == stop_pc)) begin
                  if (post_len == '0) begin
                     state_q <= TS_IDLE;
                  end else begin
                     state_q    <= TS_POST;
                     post_rem_q <= post_len;
                  end
               end
            end
            TS_POST: begin
               if (frame_end && (post_len != POST_ALL1)) begin
                  if (post_rem_q == POST_W'(1)) state_q    <= TS_IDLE;
                  else                          post_rem_q <= post_rem_q - 1'b1;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         TS_CAL:           dbg_o = (cal_q < CAL_BURST) && !cal_q[0];
         TS_TRACE, TS_POST: dbg_o = frame_bit;
         default:          dbg_o = 1'b0;
      endcase
   end

   assign status_o = state_q;
endmodule

// File: rtl/trc_trace_ctl_chk.sv
module trc_trace_ctl_chk #(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 16,
   parameter int REG_BASE = 'h0C0,
   parameter int EN_BIT   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              dbg_o,
   input logic [2:0]        status_o
);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_BASE + 2);

   logic cfg_wr;
   assign cfg_wr = reg_we && (reg_addr == A_CFG);

   // R1
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o <= 3'd4);

   // R2
   cal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd1 && $past(status_o) != 3'd1) |-> $past(cfg_wr && reg_wdata[EN_BIT]));

   // R2
   armed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd2 && $past(status_o) != 3'd2) |-> $past(status_o) == 3'd1);

   // R3
   trace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd3 && $past(status_o) != 3'd3) |-> $past(status_o) == 3'd2);

   // R6
   post_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd4 && $past(status_o) != 3'd4) |-> $past(status_o) == 3'd3);

   // R8
   kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !reg_wdata[EN_BIT]) |=> status_o == 3'd0);

   // R8
   quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd0 || status_o == 3'd2) |-> !dbg_o);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd0 && !cfg_wr) |=> status_o == 3'd0);
endmodule

bind trc_trace_ctl trc_trace_ctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE),
   .EN_BIT(POST_W + SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .dbg_o(dbg_o), .status_o(status_o)
);

// File: tb/tb_trc_trace_ctl.sv
`timescale 1ns/1ps
module tb_trc_trace_ctl;
   localparam int NC = 4;
   localparam logic [8:0] A_START = 9'h0C0;
   localparam logic [8:0] A_STOP  = 9'h0C1;
   localparam logic [8:0] A_CFG   = 9'h0C2;
   localparam logic [9:0] PC_GO   = 10'h05C;
   localparam logic [9:0] PC_END  = 10'h0A3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [9:0]  pcv [NC];
   logic [3:0]  cdv [NC];
   logic [NC*10-1:0] core_pc;
   logic [NC*4-1:0]  core_code;
   logic        dbg_o;
   logic [2:0]  status_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign core_pc   = {pcv[3], pcv[2], pcv[1], pcv[0]};
   assign core_code = {cdv[3], cdv[2], cdv[1], cdv[0]};

   trc_trace_ctl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .core_pc(core_pc), .core_code(core_code),
      .dbg_o(dbg_o), .status_o(status_o)
   );

   // behavioural reference model
   int m_state, m_cal, m_rem, m_sel, m_post;
   int m_start, m_stop;
   bit m_en;
   bit m_q[$];
   int pcs, cds;
   bit cfgw;

   task automatic push_code(input int c);
      for (int i = 3; i >= 0; i--) begin
         m_q.push_back(c[i]);
         m_q.push_back(c[i]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cal = 0; m_rem = 0; m_sel = 0; m_post = 0;
         m_start = 0; m_stop = 0; m_en = 0; m_q.delete();
      end else begin
         pcs  = pcv[m_sel];
         cds  = cdv[m_sel];
         cfgw = reg_we && reg_addr == A_CFG;
         if (cfgw && !reg_wdata[6]) begin
            m_state = 0; m_q.delete();
         end else if (cfgw && !m_en) begin
            m_state = 1; m_cal = 0; m_q.delete();
         end else begin
            case (m_state)
               1: if (m_cal == 17) m_state = 2; else m_cal++;
               2: if (pcs == m_start) begin m_state = 3; push_code(cds); end
               3, 4: begin
                  void'(m_q.pop_front());
                  if (m_q.size() == 0) begin
                     if (m_state == 3) begin
                        if (pcs == m_stop) begin
                           if (m_post == 0) m_state = 0;
                           else begin m_state = 4; m_rem = m_post; end
                        end
                     end else if (m_post != 15) begin
                        if (m_rem == 1) m_state = 0; else m_rem--;
                     end
                     if (m_state == 3 || m_state == 4) push_code(cds);
                  end
               end
               default: ;
            endcase
         end
         if (reg_we && reg_addr == A_START) m_start = int'(reg_wdata[9:0]);
         if (reg_we && reg_addr == A_STOP)  m_stop  = int'(reg_wdata[9:0]);
         if (cfgw) begin
            m_post = int'(reg_wdata[3:0]);
            m_sel  = int'(reg_wdata[5:4]);
            m_en   = reg_wdata[6];
         end
      end
   end

   function automatic string tag_of(input int st);
      case (st)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare on every clock, a quarter period after the rising edge
   int exp_dbg;
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         if (m_state == 1)                    exp_dbg = (m_cal < 16 && m_cal % 2 == 0) ? 1 : 0;
         else if (m_state == 3 || m_state == 4) exp_dbg = m_q.size() > 0 ? int'(m_q[0]) : 0;
         else                                 exp_dbg = 0;
         chk({tag_of(m_state), " status"}, int'(status_o), m_state);
         chk({tag_of(m_state), " dbg"}, int'(dbg_o), exp_dbg);
      end
   end

   task automatic wr(input logic [8:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle();
      @(posedge clk);
      #6;
   endtask

   task automatic run_lane(input int ln, input int base_code);
      for (int k = 0; k < 8; k++) begin
         pcv[ln] = (k == 0) ? PC_GO : PC_GO + 10'(k);
         cdv[ln] = 4'((base_code + k * 5) % 16);
         cyc(8);
      end
      pcv[ln] = PC_END;
      cdv[ln] = 4'hF;
      cyc(8);
      pcv[ln] = 10'h200;
      cdv[ln] = 4'h1;
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) begin pcv[i] = 10'h010; cdv[i] = 4'h0; end
      cyc(3);
      settle();
      chk("R1 reset status", int'(status_o), 0);
      chk("R1 reset dbg", int'(dbg_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(2);

      // R10: writes to other addresses leave the unit idle
      wr(9'h0C3, 16'h007F);
      wr(9'h0BF, 16'h007F);
      cyc(2);
      settle();
      chk("R10 stray write status", int'(status_o), 0);
      chk("R10 stray write dbg", int'(dbg_o), 0);

      // scenario A: lane 1, post-trigger 2 (R2 R3 R4 R5 R6)
      wr(A_START, 16'(PC_GO));
      wr(A_STOP, 16'(PC_END));
      pcv[0] = PC_GO;
      wr(A_CFG, 16'h0052);
      settle();
      chk("R2 calibrating", int'(status_o), 1);
      cyc(25);
      settle();
      chk("R3 armed waiting", int'(status_o), 2);
      chk("R5 other lane ignored", int'(status_o), 2);
      run_lane(1, 1);
      cyc(30);
      settle();
      chk("R6 idle after post window", int'(status_o), 0);
      wr(A_CFG, 16'h0052);
      cyc(4);
      settle();
      chk("R9 no restart when already enabled", int'(status_o), 0);

      // clear during calibration (R8)
      wr(A_CFG, 16'h0000);
      wr(A_CFG, 16'h0060);
      cyc(5);
      settle();
      chk("R2 calibrating again", int'(status_o), 1);
      wr(A_CFG, 16'h0020);
      settle();
      chk("R8 cleared in calibration", int'(status_o), 0);
      chk("R8 pin low", int'(dbg_o), 0);

      // scenario B: lane 2, post-trigger 0
      wr(A_CFG, 16'h0060);
      cyc(24);
      run_lane(2, 2);
      cyc(12);
      settle();
      chk("R6 zero post-trigger stops", int'(status_o), 0);

      // scenario C: lane 0, post-trigger all ones (R7 R9 R8)
      wr(A_CFG, 16'h0000);
      pcv[0] = 10'h030;
      wr(A_CFG, 16'h004F);
      cyc(24);
      pcv[0] = PC_GO; cdv[0] = 4'h3;
      cyc(8);
      pcv[0] = 10'h061; cdv[0] = 4'h2;
      cyc(3);
      wr(A_CFG, 16'h004F);
      settle();
      chk("R9 rewrite while tracing", int'(status_o), 3);
      cyc(6);
      pcv[0] = PC_END; cdv[0] = 4'hF;
      cyc(8);
      pcv[0] = 10'h200; cdv[0] = 4'h1;
      cyc(120);
      settle();
      chk("R7 post-trigger holds", int'(status_o), 4);
      wr(A_CFG, 16'h000F);
      settle();
      chk("R8 cleared in post-trigger", int'(status_o), 0);
      chk("R8 pin low after clear", int'(dbg_o), 0);
      cyc(4);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule